// File: doc/BRIEF.md
# Standard/Extended Slave Address Matcher

This block sits behind the telegram receiver of a field-bus slave. For every decoded master command it decides whether the command is meant for this slave. The inputs are the 5-bit command address, the four information bits, a broadcast flag and a call-type flag. The call-type flag tells whether information bit 3 carries the A/B select bit as it is or inverted. The slave's own address, its ID code and its first ID extension come from shadow registers. A program-mode flag is also an input.

Two addressing schemes share one 5-bit address space. A standard slave owns a whole address. An extended slave shares its address with a partner of the opposite type (A or B), and the select bit decides which of the two is meant. Address 0, broadcast commands and program mode bypass the select rule.

The decision runs in a small state machine with three states:
- **ST_WAIT**: no command in the previous cycle.
- **ST_TAKE**: the previous command was accepted; the accept pulse is high.
- **ST_DROP**: the previous command was rejected.

The transitions are evaluated on every clock edge, from any state:
- `cmd_valid` high and the command matches → ST_TAKE.
- `cmd_valid` high and the command does not match → ST_DROP.
- `cmd_valid` low → ST_WAIT.

On an accept, the mode in use and the usable data bits are captured and held.

Top module: `slave_addr_match`

## Requirements
- R1: While `rst_n` is low and right after reset, `acc_pulse` is 0, `acc_mode` is 00, `acc_data` is 0000 and `acc_mask` is 0000.
- R2: `acc_pulse` is high for exactly the one cycle after a cycle with `cmd_valid` high and a match. It never rises without `cmd_valid` in the previous cycle.
- R3: In standard mode (ID code not equal to 0xA), a command is accepted exactly when `cmd_addr` equals `own_addr`, whatever information bit 3 holds. `acc_mode` is 00 and `acc_mask` is 1111, with all four information bits passed in `acc_data`.
- R4: With ID code 0xA and a nonzero own address, `acc_mode` reports 01 (A-slave) when bit 3 of `id_ext1` is 0, and 10 (B-slave) when it is 1.
- R5: In extended mode, the select value is information bit 3 when `sel_inv` is 0 and its inverse when `sel_inv` is 1. A command is accepted only when the address matches and the select value equals bit 3 of `id_ext1`.
- R6: In extended mode, `acc_mask` is 0111 and `acc_data` bit 3 is 0.
- R7: With `own_addr` equal to 0, the slave behaves as a standard slave whatever the ID code and extension are.
- R8: A broadcast command (`cmd_bcast` high) is accepted in every mode, whatever its address or select value.
- R9: With `prog_mode` high, any command is accepted, `acc_mode` is 11 and `acc_mask` is 1111. Program mode takes priority over all other modes.
- R10: A rejected command leaves `acc_mode`, `acc_data` and `acc_mask` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe marking a decoded command |
| cmd_addr | input | 5 | Command slave address |
| cmd_info | input | 4 | Command information bits; bit 3 may carry the select bit |
| cmd_bcast | input | 1 | Command is a broadcast |
| sel_inv | input | 1 | Bit 3 of `cmd_info` carries the inverted select bit |
| own_addr | input | 5 | Shadow copy of the slave address |
| id_code | input | 4 | Shadow copy of the ID code |
| id_ext1 | input | 4 | Shadow copy of ID extension 1; bit 3 is the A/B type |
| prog_mode | input | 1 | Program mode active |
| acc_pulse | output | 1 | Accept strobe, one cycle after `cmd_valid` |
| acc_mode | output | 2 | Mode of the last accepted command: 00 std, 01 A, 10 B, 11 program |
| acc_data | output | 4 | Usable data bits of the last accepted command |
| acc_mask | output | 4 | Which `acc_data` bits carry data |

## Verification
The assertions assume that every command input, shadow register and mode flag holds a known value in each cycle where `cmd_valid` is high. They also assume that `cmd_valid` stays low during reset. The bench meets these assumptions by changing inputs only on falling clock edges. It raises `cmd_valid` for a single cycle per command and keeps it low until reset has been released. The random stimulus draws addresses that match the own address half of the time. It mixes standard and extended ID codes, both select polarities, broadcast and program mode. Directed cases cover address 0 with an extended ID code.

// File: rtl/slvm_pkg.sv
package slvm_pkg;
    typedef enum logic [1:0] {
        MD_STD  = 2'b00,
        MD_A    = 2'b01,
        MD_B    = 2'b10,
        MD_PROG = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ST_WAIT = 2'b00,
        ST_TAKE = 2'b01,
        ST_DROP = 2'b10
    } st_e;
endpackage

// File: rtl/slvm_mode_dec.sv
module slvm_mode_dec
    import slvm_pkg::*;
#(
    parameter int          ADDR_W   = 5,
    parameter int          ID_W     = 4,
    parameter logic [3:0]  EXT_CODE = 4'hA,
    parameter int          TYPE_POS = 3
) (
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ID_W-1:0]   id_code,
    input  logic [ID_W-1:0]   id_ext1,
    input  logic              prog_mode,
    output mode_e             mode
);
    localparam logic [ID_W-1:0] EXT_ID = ID_W'(EXT_CODE);

    logic addr_zero;
    logic ext_sel;

    always_comb begin
        addr_zero = (own_addr == '0);
        ext_sel   = (id_code == EXT_ID) && !addr_zero;
        if (prog_mode)
            mode = MD_PROG;
        else if (!ext_sel)
            mode = MD_STD;
        else if (id_ext1[TYPE_POS])
            mode = MD_B;
        else
            mode = MD_A;
    end
endmodule

// File: rtl/slvm_sel_cmp.sv
module slvm_sel_cmp
    import slvm_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int INFO_W  = 4,
    parameter int SEL_POS = INFO_W - 1
) (
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [INFO_W-1:0] cmd_info,
    input  logic              sel_inv,
    input  logic              cmd_bcast,
    input  mode_e             mode,
    output logic              hit
);
    logic addr_eq;
    logic sel_val;

    always_comb begin
        addr_eq = (cmd_addr == own_addr);
        sel_val = cmd_info[SEL_POS] ^ sel_inv;
        unique case (mode)
            MD_PROG: hit = 1'b1;
            MD_STD:  hit = cmd_bcast || addr_eq;
            MD_A:    hit = cmd_bcast || (addr_eq && !sel_val);
            MD_B:    hit = cmd_bcast || (addr_eq && sel_val);
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/slave_addr_match.sv
module slave_addr_match
    import slvm_pkg::*;
#(
    parameter int         ADDR_W   = 5,
    parameter int         INFO_W   = 4,
    parameter int         ID_W     = 4,
    parameter logic [3:0] EXT_CODE = 4'hA,
    parameter int         TYPE_POS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [INFO_W-1:0] cmd_info,
    input  logic              cmd_bcast,
    input  logic              sel_inv,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [ID_W-1:0]   id_code,
    input  logic [ID_W-1:0]   id_ext1,
    input  logic              prog_mode,
    output logic              acc_pulse,
    output logic [1:0]        acc_mode,
    output logic [INFO_W-1:0] acc_data,
    output logic [INFO_W-1:0] acc_mask
);
    localparam int SEL_POS = INFO_W - 1;

    mode_e             mode;
    logic              hit;
    logic [INFO_W-1:0] mask_c;
    st_e               state, state_nx;
    mode_e             mode_q;
    logic [INFO_W-1:0] data_q, mask_q;

    slvm_mode_dec #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .EXT_CODE(EXT_CODE), .TYPE_POS(TYPE_POS)
    ) u_mode (
        .own_addr(own_addr), .id_code(id_code), .id_ext1(id_ext1),
        .prog_mode(prog_mode), .mode(mode)
    );

    slvm_sel_cmp #(
        .ADDR_W(ADDR_W), .INFO_W(INFO_W), .SEL_POS(SEL_POS)
    ) u_sel (
        .cmd_addr(cmd_addr), .own_addr(own_addr), .cmd_info(cmd_info),
        .sel_inv(sel_inv), .cmd_bcast(cmd_bcast), .mode(mode), .hit(hit)
    );

    // The select bit position carries no data for A/B slaves.
    for (genvar b = 0; b < INFO_W; b++) begin : g_mask
        if (b == SEL_POS) begin : g_sel
            assign mask_c[b] = (mode == MD_STD) || (mode == MD_PROG);
        end else begin : g_dat
            assign mask_c[b] = 1'b1;
        end
    end

    always_comb begin
        if (!cmd_valid)
            state_nx = ST_WAIT;
        else if (hit)
            state_nx = ST_TAKE;
        else
            state_nx = ST_DROP;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_WAIT;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_STD;
            data_q <= '0;
            mask_q <= '0;
        end else if (cmd_valid && hit) begin
            mode_q <= mode;
            data_q <= cmd_info & mask_c;
            mask_q <= mask_c;
        end
    end

    always_comb begin
        unique case (state)
            ST_TAKE: acc_pulse = 1'b1;
            ST_WAIT: acc_pulse = 1'b0;
            ST_DROP: acc_pulse = 1'b0;
            default: acc_pulse = 1'b0;
        endcase
        acc_mode = mode_q;
        acc_data = data_q;
        acc_mask = mask_q;
    end

    // R2: pulse only follows a command strobe
    a_r2_pulse_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> $past(cmd_valid));

    // R9: program mode accepts everything
    a_r9_prog_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && prog_mode) |=> (acc_pulse && acc_mode == 2'b11));

    // R8: broadcast always accepted
    a_r8_bcast_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_bcast) |=> acc_pulse);

    // R6: extended modes never report select bit as data
    a_r6_ext_no_sel_data: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode == 2'b01 || acc_mode == 2'b10) |-> (!acc_mask[SEL_POS] && !acc_data[SEL_POS]));

    // R3: address mismatch without broadcast or program mode is rejected
    a_r3_addr_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !prog_mode && !cmd_bcast && cmd_addr != own_addr) |=> !acc_pulse);

    // R7: address zero behaves as standard slave
    a_r7_zero_standard: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !prog_mode && own_addr == '0 && cmd_addr == '0) |=> (acc_pulse && acc_mode == 2'b00));

    // R10: rejected command leaves captured outputs alone
    a_r10_hold_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !prog_mode && !cmd_bcast && cmd_addr != own_addr)
        |=> ($stable(acc_mode) && $stable(acc_data) && $stable(acc_mask)));
endmodule

// File: tb/slave_addr_match_tb.sv
module slave_addr_match_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [4:0] cmd_addr = '0;
    logic [3:0] cmd_info = '0;
    logic       cmd_bcast = 1'b0;
    logic       sel_inv = 1'b0;
    logic [4:0] own_addr = '0;
    logic [3:0] id_code = '0;
    logic [3:0] id_ext1 = '0;
    logic       prog_mode = 1'b0;
    logic       acc_pulse;
    logic [1:0] acc_mode;
    logic [3:0] acc_data, acc_mask;

    int checks = 0;
    int fails  = 0;
    logic [1:0] e_mode = 2'b00;
    logic [3:0] e_data = 4'h0, e_mask = 4'h0;

    always #2 clk = ~clk;

    slave_addr_match u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_info(cmd_info), .cmd_bcast(cmd_bcast), .sel_inv(sel_inv),
        .own_addr(own_addr), .id_code(id_code), .id_ext1(id_ext1),
        .prog_mode(prog_mode), .acc_pulse(acc_pulse), .acc_mode(acc_mode),
        .acc_data(acc_data), .acc_mask(acc_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] ref_mode();
        if (prog_mode) return 2'b11;
        if (own_addr == 5'd0 || id_code != 4'hA) return 2'b00;
        return id_ext1[3] ? 2'b10 : 2'b01;
    endfunction

    function automatic logic ref_hit();
        logic [1:0] m;
        logic s;
        m = ref_mode();
        s = cmd_info[3] ^ sel_inv;
        if (m == 2'b11 || cmd_bcast) return 1'b1;
        if (cmd_addr != own_addr) return 1'b0;
        if (m == 2'b00) return 1'b1;
        return s == id_ext1[3];
    endfunction

    function automatic string ref_tag();
        if (prog_mode) return "R9";
        if (cmd_bcast) return "R8";
        if (own_addr == 5'd0) return "R7";
        if (id_code == 4'hA) return "R5";
        return "R3";
    endfunction

    // Inputs already set at a falling edge; issue one strobe and check.
    task automatic send();
        logic h;
        logic [1:0] m;
        string t;
        h = ref_hit();
        m = ref_mode();
        t = ref_tag();
        if (h) begin
            e_mode = m;
            e_mask = (m == 2'b01 || m == 2'b10) ? 4'h7 : 4'hF;
            e_data = cmd_info & e_mask;
        end
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({t, " accept"}, 32'(acc_pulse), 32'(h));
        chk(h ? {t, " mode"} : "R10 mode", 32'(acc_mode), 32'(e_mode));
        chk(m[0] ^ m[1] ? "R6 data" : (h ? {t, " data"} : "R10 data"), 32'(acc_data), 32'(e_data));
        chk(h ? {t, " mask"} : "R10 mask", 32'(acc_mask), 32'(e_mask));
        @(negedge clk);
        chk("R2 single pulse", 32'(acc_pulse), 32'd0);
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 pulse", 32'(acc_pulse), 32'd0);
        chk("R1 mode", 32'(acc_mode), 32'd0);
        chk("R1 data", 32'(acc_data), 32'd0);
        chk("R1 mask", 32'(acc_mask), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle no pulse", 32'(acc_pulse), 32'd0);

        // R3: standard, I3 set, match
        own_addr = 5'd9; id_code = 4'h3; cmd_addr = 5'd9; cmd_info = 4'hB; send();
        // R4/R5: A-slave, select 0 direct
        id_code = 4'hA; id_ext1 = 4'h0; cmd_info = 4'h5; sel_inv = 1'b0; send();
        chk("R4 A mode", 32'(acc_mode), 32'd1);
        // R5: A-slave with inverted select -> rejected (R10 hold)
        sel_inv = 1'b1; cmd_info = 4'h2; send();
        // R4/R5: B-slave, inverted select with I3=0 means select 1
        id_ext1 = 4'h8; cmd_info = 4'h6; send();
        chk("R4 B mode", 32'(acc_mode), 32'd2);
        // R7: address 0 with extended ID code, any I3
        own_addr = 5'd0; cmd_addr = 5'd0; cmd_info = 4'hF; sel_inv = 1'b0; send();
        // R8: broadcast to B-slave with wrong address and select
        own_addr = 5'd20; cmd_addr = 5'd3; cmd_bcast = 1'b1; cmd_info = 4'h0; send();
        cmd_bcast = 1'b0;
        // R9: program mode, mismatched address, extended ID
        prog_mode = 1'b1; cmd_info = 4'hC; send();
        prog_mode = 1'b0;
        // R2: back-to-back accepts
        own_addr = 5'd7; id_code = 4'h1; cmd_addr = 5'd7; cmd_valid = 1'b1;
        @(negedge clk);
        chk("R2 back1", 32'(acc_pulse), 32'd1);
        @(negedge clk);
        chk("R2 back2", 32'(acc_pulse), 32'd1);
        cmd_valid = 1'b0;
        e_mode = 2'b00; e_mask = 4'hF; e_data = cmd_info;
        @(negedge clk);
        chk("R2 back end", 32'(acc_pulse), 32'd0);

        for (int i = 0; i < 400; i++) begin
            own_addr  = 5'($urandom_range(0, 31));
            cmd_addr  = ($urandom_range(0, 1) == 1) ? own_addr : 5'($urandom_range(0, 31));
            cmd_info  = 4'($urandom_range(0, 15));
            sel_inv   = 1'($urandom_range(0, 1));
            id_code   = ($urandom_range(0, 1) == 1) ? 4'hA : 4'($urandom_range(0, 15));
            id_ext1   = 4'($urandom_range(0, 15));
            cmd_bcast = ($urandom_range(0, 9) == 0);
            prog_mode = ($urandom_range(0, 9) == 0);
            send();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule